// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Stage

This block is the metric engine of a hard-decision Viterbi decoder for a rate-1/2 convolutional code. Each accepted stage takes one two-bit received pair. For every trellis state the block scores the two branches that enter it by Hamming distance. It adds each score to the stored metric of the state the branch comes from and keeps the smaller sum. It also reports which of the two predecessors won. A traceback unit downstream consumes the per-state decision vector and the metric bank.

The constraint length, the metric width and both generator tap words are parameters. The trellis is split into butterflies. Each butterfly reads one even/odd pair of old states and writes two new states, one half of the state space apart. Metrics are renormalised inside the same stage, so the registers never wrap on an arbitrarily long stream.

Top module: `vit_acs_unit`

## Requirements
- R1: The state count NS is 2^(K-1), and K must lie between 5 and 9 inclusive.
- R2: After reset, the metric of state 0 is 0 and the metric of every other state is 2^(W-2). `dec_valid` is low.
- R3: The expected pair on a branch is {parity(T & G0), parity(T & G1)}, where the tap word T is K bits wide: the new input bit in bit K-1, followed by the K-1 bits of the old state. The branch metric is the number of differing bits between this pair and `sym` (0 to 2).
- R4: Input bit u moves old state s to state {u, s[K-2:1]}. New state j therefore has predecessors 2*(j mod NS/2) (even) and that value plus 1 (odd).
- R5: The new metric of each state is the smaller of its two candidates. Its decision bit `dec[j]` is 1 only when the odd predecessor's candidate is strictly smaller. A tie selects the even predecessor.
- R6: When the smallest stored metric is at least 2^(W-1), 2^(W-1) is taken off every candidate in that stage. After any stage the smallest metric is below 2^(W-1)+2.
- R7: No stored metric ever reaches 3*2^(W-2).
- R8: A stage accepted on a clock edge with `sym_valid` high raises `dec_valid` for exactly the following cycle. The new `dec` and `pm_out` values are visible in that same cycle.
- R9: While `sym_valid` is low, the metrics hold their values and `dec_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Accept `sym` as one trellis stage on this edge |
| sym | input | 2 | Received hard-decision pair; bit 1 is compared with the G0 output |
| dec_valid | output | 1 | One-cycle strobe for `dec` after each accepted stage |
| dec | output | NS | Survivor decision per state; 1 selects the odd predecessor |
| pm_out | output | NS*W | Path metric bank; state j at bits [j*W +: W] |

## Verification
On every cycle, the assertions check the reset image of the metric bank, the strobe timing, the metric hold while idle, the ceiling that rules out overflow, and the floor that normalisation keeps the smallest metric under. The per-state arithmetic can only be shown by the bench scenarios. These cover the exact metric values, the tie-breaking direction, the predecessor mapping, and the zero metric of the true encoder state on a clean codeword. The bench runs a trellis model beside the design over clean, noisy and long streams, and compares every metric and decision bit at each stage.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

    // Expected coded pair for a K-bit tap word: {G0 output, G1 output}
    function automatic logic [1:0] code_pair(input int unsigned tap,
                                             input int unsigned g0,
                                             input int unsigned g1);
        logic [31:0] t0;
        logic [31:0] t1;
        t0 = tap & g0;
        t1 = tap & g1;
        return {^t0, ^t1};
    endfunction

    // Hamming distance between two 2-bit pairs
    function automatic logic [1:0] hamming2(input logic [1:0] a,
                                            input logic [1:0] b);
        logic [1:0] x;
        x = a ^ b;
        return {1'b0, x[1]} + {1'b0, x[0]};
    endfunction

    // Result of one compare-select
    typedef struct packed {
        logic odd_wins;
    } acs_sel_t;

endpackage

// File: rtl/vit_acs_cell.sv
module vit_acs_cell #(
    parameter int W = 8
) (
    input  logic [W-1:0] m_even,
    input  logic [W-1:0] m_odd,
    input  logic [1:0]   bm_even,
    input  logic [1:0]   bm_odd,
    input  logic [W-1:0] offset,
    output logic [W-1:0] m_new,
    output logic         sel
);
    import vit_acs_pkg::*;

    logic [W-1:0] cand_e;
    logic [W-1:0] cand_o;
    acs_sel_t     pick;

    always_comb begin
        cand_e        = m_even - offset + {{(W-2){1'b0}}, bm_even};
        cand_o        = m_odd  - offset + {{(W-2){1'b0}}, bm_odd};
        pick.odd_wins = (cand_o < cand_e);
        m_new         = pick.odd_wins ? cand_o : cand_e;
        sel           = pick.odd_wins;
    end
endmodule

// File: rtl/vit_bfly.sv
module vit_bfly #(
    parameter int          K   = 5,
    parameter int          W   = 8,
    parameter int unsigned G0  = 19,
    parameter int unsigned G1  = 29,
    parameter int          IDX = 0
) (
    input  logic [W-1:0] pm_even,
    input  logic [W-1:0] pm_odd,
    input  logic [1:0]   sym,
    input  logic [W-1:0] offset,
    output logic [W-1:0] pm_lo,
    output logic [W-1:0] pm_hi,
    output logic         dec_lo,
    output logic         dec_hi
);
    import vit_acs_pkg::*;

    localparam int unsigned PE    = 2 * IDX;
    localparam int unsigned PO    = 2 * IDX + 1;
    localparam int unsigned UBIT  = 1 << (K - 1);
    localparam logic [1:0]  EX_LE = code_pair(PE, G0, G1);
    localparam logic [1:0]  EX_LO = code_pair(PO, G0, G1);
    localparam logic [1:0]  EX_HE = code_pair(UBIT | PE, G0, G1);
    localparam logic [1:0]  EX_HO = code_pair(UBIT | PO, G0, G1);

    logic [1:0] bm_le, bm_lo, bm_he, bm_ho;

    always_comb begin
        bm_le = hamming2(sym, EX_LE);
        bm_lo = hamming2(sym, EX_LO);
        bm_he = hamming2(sym, EX_HE);
        bm_ho = hamming2(sym, EX_HO);
    end

    vit_acs_cell #(.W(W)) u_lo (
        .m_even (pm_even), .m_odd (pm_odd),
        .bm_even(bm_le),   .bm_odd(bm_lo),
        .offset (offset),  .m_new (pm_lo), .sel(dec_lo)
    );

    vit_acs_cell #(.W(W)) u_hi (
        .m_even (pm_even), .m_odd (pm_odd),
        .bm_even(bm_he),   .bm_odd(bm_ho),
        .offset (offset),  .m_new (pm_hi), .sel(dec_hi)
    );
endmodule

// File: rtl/vit_min_find.sv
module vit_min_find #(
    parameter int N = 16,
    parameter int W = 8
) (
    input  logic [W-1:0] vals [N],
    output logic [W-1:0] min_val
);
    always_comb begin
        min_val = vals[0];
        for (int i = 1; i < N; i++) begin
            if (vals[i] < min_val) min_val = vals[i];
        end
    end
endmodule

// File: rtl/vit_acs_unit.sv
module vit_acs_unit #(
    parameter  int          K  = 5,
    parameter  int          W  = 8,
    parameter  int unsigned G0 = 19,
    parameter  int unsigned G1 = 29,
    localparam int          NS = 1 << (K - 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sym_valid,
    input  logic [1:0]      sym,
    output logic            dec_valid,
    output logic [NS-1:0]   dec,
    output logic [NS*W-1:0] pm_out
);
    localparam int         HALF_NS = NS / 2;
    localparam logic [W-1:0] HALF  = W'(1) << (W - 1);
    localparam logic [W-1:0] INIT  = W'(1) << (W - 2);

    logic [W-1:0] pm_q   [NS];
    logic [W-1:0] pm_nxt [NS];
    logic [NS-1:0] dec_nxt;
    logic [W-1:0] old_min;
    logic [W-1:0] offset;

    vit_min_find #(.N(NS), .W(W)) u_min (
        .vals   (pm_q),
        .min_val(old_min)
    );

    assign offset = (old_min >= HALF) ? HALF : '0;

    for (genvar b = 0; b < HALF_NS; b++) begin : g_bfly
        vit_bfly #(.K(K), .W(W), .G0(G0), .G1(G1), .IDX(b)) u_bf (
            .pm_even(pm_q[2*b]),
            .pm_odd (pm_q[2*b+1]),
            .sym    (sym),
            .offset (offset),
            .pm_lo  (pm_nxt[b]),
            .pm_hi  (pm_nxt[b+HALF_NS]),
            .dec_lo (dec_nxt[b]),
            .dec_hi (dec_nxt[b+HALF_NS])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NS; j++) pm_q[j] <= (j == 0) ? '0 : INIT;
            dec       <= '0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= sym_valid;
            if (sym_valid) begin
                for (int j = 0; j < NS; j++) pm_q[j] <= pm_nxt[j];
                dec <= dec_nxt;
            end
        end
    end

    for (genvar j = 0; j < NS; j++) begin : g_out
        assign pm_out[j*W +: W] = pm_q[j];
    end
endmodule

// File: rtl/vit_acs_chk.sv
module vit_acs_chk #(
    parameter int K = 5,
    parameter int W = 8,
    localparam int NS = 1 << (K - 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            sym_valid,
    input logic            dec_valid,
    input logic [NS*W-1:0] pm_out
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);
    localparam logic [W-1:0] INIT = W'(1) << (W - 2);
    localparam logic [W-1:0] CEIL = W'(3) << (W - 2);

    logic [NS*W-1:0] init_img;
    logic [W-1:0]    cur_min;
    logic            over_ceil;

    always_comb begin
        init_img  = '0;
        cur_min   = pm_out[W-1:0];
        over_ceil = 1'b0;
        for (int j = 0; j < NS; j++) begin
            init_img[j*W +: W] = (j == 0) ? '0 : INIT;
            if (pm_out[j*W +: W] < cur_min) cur_min = pm_out[j*W +: W];
            if (pm_out[j*W +: W] >= CEIL) over_ceil = 1'b1;
        end
    end

    initial begin
        AST_K_RANGE: assert (K >= 5 && K <= 9); // R1
    end

    AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pm_out == init_img && !dec_valid)); // R2

    AST_STROBE: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> dec_valid); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> (!dec_valid && $stable(pm_out))); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !over_ceil); // R7

    AST_NORM_FLOOR: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (cur_min < HALF + 2)); // R6
endmodule

bind vit_acs_unit vit_acs_chk #(.K(K), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sym_valid(sym_valid),
    .dec_valid(dec_valid),
    .pm_out   (pm_out)
);

// File: tb/vit_acs_unit_tb.sv
module vit_acs_unit_tb;
    localparam int          K  = 5;
    localparam int          W  = 8;
    localparam int unsigned G0 = 19;
    localparam int unsigned G1 = 29;
    localparam int          NS = 1 << (K - 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sym_valid = 1'b0;
    logic [1:0]      sym = 2'b00;
    logic            dec_valid;
    logic [NS-1:0]   dec;
    logic [NS*W-1:0] pm_out;

    int total = 0;
    int bad   = 0;
    int model [NS];
    int norm_count = 0;
    int tie_count  = 0;
    int max_seen   = 0;
    int enc_state  = 0;

    always #10 clk = ~clk;

    vit_acs_unit #(.K(K), .W(W), .G0(G0), .G1(G1)) u_dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym),
        .dec_valid(dec_valid), .dec(dec), .pm_out(pm_out)
    );

    function automatic logic [1:0] exp_pair(int tap);
        int unsigned a, b;
        a = tap & G0;
        b = tap & G1;
        return {logic'($countones(a) % 2), logic'($countones(b) % 2)};
    endfunction

    function automatic int ham(logic [1:0] a, logic [1:0] b);
        return $countones(a ^ b);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int j = 0; j < NS; j++) model[j] = (j == 0) ? 0 : (1 << (W - 2));
    endtask

    // Apply one stage to design and model, then compare (R3 R4 R5 R6 R8)
    task automatic stage(logic [1:0] s);
        int mn, off;
        int nm [NS];
        logic [NS-1:0] ed;
        bit mok;
        mn = model[0];
        for (int j = 1; j < NS; j++) if (model[j] < mn) mn = model[j];
        off = (mn >= (1 << (W - 1))) ? (1 << (W - 1)) : 0;
        if (off != 0) norm_count++;
        for (int j = 0; j < NS; j++) begin
            int pe, po, u, ce, co;
            pe = (j << 1) & (NS - 1);
            po = pe | 1;
            u  = j >> (K - 2);
            ce = model[pe] - off + ham(s, exp_pair((u << (K - 1)) | pe));
            co = model[po] - off + ham(s, exp_pair((u << (K - 1)) | po));
            if (ce == co) tie_count++;
            ed[j] = (co < ce);
            nm[j] = (co < ce) ? co : ce;
        end
        for (int j = 0; j < NS; j++) begin
            model[j] = nm[j];
            if (nm[j] > max_seen) max_seen = nm[j];
        end
        @(negedge clk);
        sym_valid = 1'b1;
        sym = s;
        @(negedge clk);
        sym_valid = 1'b0;
        check(dec_valid == 1'b1, "R8", "dec_valid after stage", int'(dec_valid), 1);
        check(dec == ed, "R5", "decision vector", int'(dec), int'(ed));
        mok = 1'b1;
        for (int j = 0; j < NS; j++) begin
            if (int'(pm_out[j*W +: W]) != model[j]) begin
                mok = 1'b0;
                check(1'b0, "R3", $sformatf("metric state %0d", j),
                      int'(pm_out[j*W +: W]), model[j]);
            end
        end
        if (mok) check(1'b1, "R3", "metric bank", 0, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        sym_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model_reset();
        enc_state = 0;
        check(dec_valid == 1'b0, "R2", "dec_valid after reset", int'(dec_valid), 0);
        for (int j = 0; j < NS; j++)
            check(int'(pm_out[j*W +: W]) == model[j], "R2",
                  $sformatf("reset metric %0d", j), int'(pm_out[j*W +: W]), model[j]);
        check(($bits(dec) == 16) && (K >= 5) && (K <= 9), "R1", "state count",
              $bits(dec), 16);
    endtask

    // Clean codeword: the true encoder state keeps metric zero (R3 R4)
    task automatic t_clean();
        for (int i = 0; i < 30; i++) begin
            int u, tap;
            u   = $urandom % 2;
            tap = (u << (K - 1)) | enc_state;
            stage(exp_pair(tap));
            enc_state = tap >> 1;
            if (i >= K - 1)
                check(pm_out[enc_state*W +: W] == '0, "R4", "true state metric",
                      int'(pm_out[enc_state*W +: W]), 0);
        end
    endtask

    // Noisy and fixed patterns exercise the select and tie rules (R5)
    task automatic t_noisy();
        stage(2'b11); stage(2'b11); stage(2'b00); stage(2'b01);
        stage(2'b10); stage(2'b10); stage(2'b01); stage(2'b11);
        for (int i = 0; i < 40; i++) stage(2'($urandom % 4));
        check(tie_count > 0, "R5", "ties encountered", tie_count, 1);
    endtask

    // Idle cycles keep everything (R9)
    task automatic t_idle();
        logic [NS*W-1:0] snap;
        snap = pm_out;
        repeat (5) begin
            @(negedge clk);
            sym = 2'($urandom % 4);
            check(dec_valid == 1'b0, "R9", "dec_valid idle", int'(dec_valid), 0);
            check(pm_out == snap, "R9", "metrics idle", int'(pm_out[W-1:0]),
                  int'(snap[W-1:0]));
        end
    endtask

    // Long random stream crosses the normalisation threshold (R6 R7)
    task automatic t_norm();
        for (int i = 0; i < 900; i++) stage(2'($urandom % 4));
        check(norm_count > 0, "R6", "normalisations seen", norm_count, 1);
        check(max_seen < 3 * (1 << (W - 2)), "R7", "largest metric", max_seen,
              3 * (1 << (W - 2)) - 1);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_noisy();
        t_idle();
        t_norm();
        t_reset();
        t_clean();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule